// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits beside a processor's instruction pipeline and decides, at each instruction boundary, whether a pending interrupt is taken. It owns the processor status word, an enable bit and a 3-bit current-level field. Maskable requests arrive with a 3-bit priority and a 5-bit cause number. A separate active-low non-maskable line is watched for a falling edge. Once a request is taken, the block saves the interrupted PC and then the status word to a stack. It then updates the status word, fetches the handler address from a vector table and hands that address to the pipeline as the new PC.

A return command runs the reverse sequence. It reads the saved PC and then the saved status word from the stack. It restores the status word and hands the saved PC back to the pipeline. Software may set the enable bit inside a handler, so that a request of strictly higher priority can nest.

The stack port and the vector port are valid/ready channels. A beat completes in a cycle in which both valid and ready are high. While valid is high and ready is low, the block holds valid, the address, the direction and the write data unchanged. The stack responder returns read data in the completing cycle, and so does the vector responder. The responders may hold ready low for any number of cycles. All other pins are plain level signals sampled on the rising clock edge.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the enable bit is 0, the level field is 0, busy is 0, no channel is valid, and the stack pointer equals SP_RESET (default 0x100).
- R2: A maskable request is accepted only in a cycle where instr_done is 1 and the enable bit is 1; with the enable bit at 0 a request is never acknowledged.
- R3: A maskable request is accepted only if its priority is strictly greater than the level field; a request at the same level or below is not acknowledged.
- R4: A falling edge on nmi_n is remembered until it is taken at the next instruction boundary. It is taken whatever the enable bit is, it wins over any maskable request in the same cycle, and it uses cause number 2. It clears the enable bit and leaves the level field unchanged. One edge produces exactly one entry.
- R5: Entry first writes the PC captured at acceptance to address sp-4 and then writes the status word to address sp-8. Each write lowers the stack pointer by 4. The status word holds the enable bit in bit 0, the level field in bits 3:1, and zero in all other bits.
- R6: When the status-word write completes, the enable bit becomes 0 and the level field takes the accepted priority; while the vector is fetched the enable bit is already 0.
- R7: The vector read uses address VEC_BASE + 4 x cause (default base 0x1000). The returned word appears on pc_out with a one-cycle pc_load pulse in the cycle after the read completes.
- R8: busy rises in the cycle after acceptance and falls in the same cycle as pc_load. While busy is high no request is acknowledged, so a request held across a whole entry produces one acknowledgement.
- R9: A return command issued while busy is 0 first reads the saved PC at sp+4 and then the saved status word at sp. Each read raises the stack pointer by 4. The restored enable bit and level field take effect, and the saved PC appears on pc_out with a pc_load pulse.
- R10: On both channels a beat stalled by ready=0 keeps valid, address, direction and write data stable until it completes, and back-pressure changes no saved value.
- R11: Setting the enable bit by software write inside a handler lets a request of strictly higher priority nest, saving the handler's enable bit and level in the pushed status word.
- R12: irq_ack is high in the acceptance cycle, and irq_ack_cause then shows the accepted cause number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_done | input | 1 | Last cycle of the current instruction (boundary) |
| ret_cmd | input | 1 | Return-from-handler command |
| pc_in | input | 32 | PC to save if an interrupt is accepted |
| req_valid | input | 1 | Maskable request present |
| req_level | input | 3 | Priority of the maskable request |
| req_cause | input | 5 | Cause number of the maskable request |
| nmi_n | input | 1 | Non-maskable request, active low |
| sw_ie_we | input | 1 | Software write strobe for the enable bit |
| sw_ie_val | input | 1 | Value written to the enable bit |
| irq_ack | output | 1 | Request accepted this cycle |
| irq_ack_cause | output | 5 | Cause number of the accepted request |
| busy | output | 1 | Entry or return sequence in progress |
| ie_out | output | 1 | Current enable bit |
| il_out | output | 3 | Current level field |
| sp_out | output | 32 | Current stack pointer |
| stk_valid | output | 1 | Stack beat valid |
| stk_ready | input | 1 | Stack beat ready |
| stk_write | output | 1 | 1 for a push (write), 0 for a pop (read) |
| stk_addr | output | 32 | Stack beat address |
| stk_wdata | output | 32 | Push data |
| stk_rdata | input | 32 | Pop data, valid in the completing cycle |
| vec_valid | output | 1 | Vector read valid |
| vec_ready | input | 1 | Vector read ready |
| vec_addr | output | 32 | Vector table address |
| vec_rdata | input | 32 | Handler address, valid in the completing cycle |
| pc_load | output | 1 | One-cycle strobe: load pc_out into the PC |
| pc_out | output | 32 | New PC value |

## Verification
Several properties are checked on every cycle. Stalled beats on either channel must hold stable. Each completed push must lower the stack pointer by 4, and each completed pop must raise it by 4. The enable bit must already be clear whenever the vector is being fetched. Every maskable entry must raise the level field. Other behaviours only show in the bench's scenarios. These are the rejection of an equal-level or disabled request, the ordering and contents of the saved words, the precedence of the non-maskable input, the single acknowledgement of a request held through a busy entry, and the restore done by nested returns.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int LVL_W   = 3;
  localparam int CAUSE_W = 5;
  localparam int WORD_W  = 32;
  localparam int NMI_CAUSE = 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_PC,
    S_PUSH_SR,
    S_VEC,
    S_POP_PC,
    S_POP_SR
  } seq_state_e;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             en;
  } status_t;

  function automatic logic [WORD_W-1:0] sr_pack(status_t s);
    return {{(WORD_W-LVL_W-1){1'b0}}, s.lvl, s.en};
  endfunction

  function automatic status_t sr_unpack(logic [WORD_W-1:0] w);
    status_t s;
    s.en  = w[0];
    s.lvl = w[LVL_W:1];
    return s;
  endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary,
  input  logic               nmi_n,
  input  logic               req_valid,
  input  logic [LVL_W-1:0]   req_level,
  input  logic [CAUSE_W-1:0] req_cause,
  input  status_t            cur,
  output logic               accept,
  output logic               sel_nmi,
  output logic [CAUSE_W-1:0] sel_cause,
  output logic [LVL_W-1:0]   sel_level
);

  logic nmi_q;
  logic nmi_pend;
  logic mask_ok;

  // falling-edge capture of the non-maskable line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_n;
      if (nmi_q && !nmi_n)
        nmi_pend <= 1'b1;
      else if (accept && sel_nmi)
        nmi_pend <= 1'b0;
    end
  end

  always_comb begin
    mask_ok   = cur.en && req_valid && (req_level > cur.lvl);
    accept    = boundary && (nmi_pend || mask_ok);
    sel_nmi   = nmi_pend;
    sel_cause = nmi_pend ? CAUSE_W'(NMI_CAUSE) : req_cause;
    sel_level = nmi_pend ? cur.lvl : req_level;
  end

endmodule

// File: rtl/irq_status.sv
module irq_status
  import irq_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic             sw_val,
  input  logic             ent_upd,
  input  logic             ent_nmi,
  input  logic [LVL_W-1:0] ent_level,
  input  logic             rest_upd,
  input  status_t          rest_val,
  output status_t          cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (rest_upd) begin
      cur <= rest_val;
    end else if (ent_upd) begin
      cur.en <= 1'b0;
      if (!ent_nmi) cur.lvl <= ent_level;
    end else if (sw_we) begin
      cur.en <= sw_val;
    end
  end

  // a maskable entry always raises the level field
  p_level_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_upd && !ent_nmi && !rest_upd) |=> (cur.lvl > $past(cur.lvl)));

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = 'h1000,
  parameter logic [ADDR_W-1:0] SP_RESET = 'h100
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               ret_go,
  input  logic               sel_nmi,
  input  logic [CAUSE_W-1:0] sel_cause,
  input  logic [LVL_W-1:0]   sel_level,
  input  logic [WORD_W-1:0]  pc_in,
  input  status_t            cur,
  output logic               busy,
  output logic [ADDR_W-1:0]  sp,
  output logic               stk_valid,
  input  logic               stk_ready,
  output logic               stk_write,
  output logic [ADDR_W-1:0]  stk_addr,
  output logic [WORD_W-1:0]  stk_wdata,
  input  logic [WORD_W-1:0]  stk_rdata,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [ADDR_W-1:0]  vec_addr,
  input  logic [WORD_W-1:0]  vec_rdata,
  output logic               pc_load,
  output logic [WORD_W-1:0]  pc_out,
  output logic               ent_upd,
  output logic               ent_nmi,
  output logic [LVL_W-1:0]   ent_level,
  output logic               rest_upd,
  output status_t            rest_val
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
  localparam int PAD_W = ADDR_W - CAUSE_W - 2;

  seq_state_e state, nstate;
  logic [WORD_W-1:0]  pc_cap;
  logic [CAUSE_W-1:0] cause_cap;
  logic               stk_fire, vec_fire;

  assign stk_fire = stk_valid && stk_ready;
  assign vec_fire = vec_valid && vec_ready;

  always_comb begin
    nstate = state;
    unique case (state)
      S_IDLE:    if (ret_go) nstate = S_POP_PC;
                 else if (accept) nstate = S_PUSH_PC;
      S_PUSH_PC: if (stk_ready) nstate = S_PUSH_SR;
      S_PUSH_SR: if (stk_ready) nstate = S_VEC;
      S_VEC:     if (vec_ready) nstate = S_IDLE;
      S_POP_PC:  if (stk_ready) nstate = S_POP_SR;
      S_POP_SR:  if (stk_ready) nstate = S_IDLE;
      default:   nstate = S_IDLE;
    endcase
  end

  always_comb begin
    busy      = (state != S_IDLE);
    stk_valid = (state == S_PUSH_PC) || (state == S_PUSH_SR) ||
                (state == S_POP_PC)  || (state == S_POP_SR);
    stk_write = (state == S_PUSH_PC) || (state == S_PUSH_SR);
    unique case (state)
      S_PUSH_PC, S_PUSH_SR, S_POP_SR: stk_addr = sp - STEP;
      S_POP_PC:                        stk_addr = sp + STEP;
      default:                         stk_addr = sp;
    endcase
    stk_wdata = (state == S_PUSH_PC) ? pc_cap : sr_pack(cur);
    vec_valid = (state == S_VEC);
    vec_addr  = VEC_BASE + {{PAD_W{1'b0}}, cause_cap, 2'b00};
    ent_upd   = (state == S_PUSH_SR) && stk_ready;
    rest_upd  = (state == S_POP_SR) && stk_ready;
    rest_val  = sr_unpack(stk_rdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sp        <= SP_RESET;
      pc_cap    <= '0;
      cause_cap <= '0;
      ent_nmi   <= 1'b0;
      ent_level <= '0;
      pc_load   <= 1'b0;
      pc_out    <= '0;
    end else begin
      state   <= nstate;
      pc_load <= 1'b0;
      if (state == S_IDLE && !ret_go && accept) begin
        pc_cap    <= pc_in;
        cause_cap <= sel_cause;
        ent_nmi   <= sel_nmi;
        ent_level <= sel_level;
      end
      if (stk_fire) begin
        sp <= stk_write ? sp - STEP : sp + STEP;
        if (state == S_POP_PC) pc_cap <= stk_rdata;
      end
      if (vec_fire) begin
        pc_load <= 1'b1;
        pc_out  <= vec_rdata;
      end else if (state == S_POP_SR && stk_ready) begin
        pc_load <= 1'b1;
        pc_out  <= pc_cap;
      end
    end
  end

  p_stk_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr) &&
                                   $stable(stk_write) && $stable(stk_wdata)));

  p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));

  p_sp_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_fire && stk_write) |=> (sp == $past(sp) - STEP));

  p_sp_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_fire && !stk_write) |=> (sp == $past(sp) + STEP));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = 'h1000,
  parameter logic [ADDR_W-1:0] SP_RESET = 'h100
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_done,
  input  logic               ret_cmd,
  input  logic [WORD_W-1:0]  pc_in,
  input  logic               req_valid,
  input  logic [LVL_W-1:0]   req_level,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic               nmi_n,
  input  logic               sw_ie_we,
  input  logic               sw_ie_val,
  output logic               irq_ack,
  output logic [CAUSE_W-1:0] irq_ack_cause,
  output logic               busy,
  output logic               ie_out,
  output logic [LVL_W-1:0]   il_out,
  output logic [ADDR_W-1:0]  sp_out,
  output logic               stk_valid,
  input  logic               stk_ready,
  output logic               stk_write,
  output logic [ADDR_W-1:0]  stk_addr,
  output logic [WORD_W-1:0]  stk_wdata,
  input  logic [WORD_W-1:0]  stk_rdata,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [ADDR_W-1:0]  vec_addr,
  input  logic [WORD_W-1:0]  vec_rdata,
  output logic               pc_load,
  output logic [WORD_W-1:0]  pc_out
);

  status_t            cur;
  logic               boundary, ret_go, accept, sel_nmi;
  logic [CAUSE_W-1:0] sel_cause;
  logic [LVL_W-1:0]   sel_level, ent_level;
  logic               ent_upd, ent_nmi, rest_upd;
  status_t            rest_val;

  assign ret_go   = ret_cmd && !busy;
  assign boundary = instr_done && !busy && !ret_cmd;

  irq_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .nmi_n     (nmi_n),
    .req_valid (req_valid),
    .req_level (req_level),
    .req_cause (req_cause),
    .cur       (cur),
    .accept    (accept),
    .sel_nmi   (sel_nmi),
    .sel_cause (sel_cause),
    .sel_level (sel_level)
  );

  irq_status u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (sw_ie_we),
    .sw_val    (sw_ie_val),
    .ent_upd   (ent_upd),
    .ent_nmi   (ent_nmi),
    .ent_level (ent_level),
    .rest_upd  (rest_upd),
    .rest_val  (rest_val),
    .cur       (cur)
  );

  irq_seq_fsm #(
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE),
    .SP_RESET (SP_RESET)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .ret_go    (ret_go),
    .sel_nmi   (sel_nmi),
    .sel_cause (sel_cause),
    .sel_level (sel_level),
    .pc_in     (pc_in),
    .cur       (cur),
    .busy      (busy),
    .sp        (sp_out),
    .stk_valid (stk_valid),
    .stk_ready (stk_ready),
    .stk_write (stk_write),
    .stk_addr  (stk_addr),
    .stk_wdata (stk_wdata),
    .stk_rdata (stk_rdata),
    .vec_valid (vec_valid),
    .vec_ready (vec_ready),
    .vec_addr  (vec_addr),
    .vec_rdata (vec_rdata),
    .pc_load   (pc_load),
    .pc_out    (pc_out),
    .ent_upd   (ent_upd),
    .ent_nmi   (ent_nmi),
    .ent_level (ent_level),
    .rest_upd  (rest_upd),
    .rest_val  (rest_val)
  );

  assign irq_ack       = accept;
  assign irq_ack_cause = sel_cause;
  assign ie_out        = cur.en;
  assign il_out        = cur.lvl;

  // status push precedes the vector fetch, so the enable bit is already off
  p_ie_off_in_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !ie_out);

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 0, ret_cmd = 0;
  logic [31:0] pc_in = '0;
  logic        req_valid = 0;
  logic [2:0]  req_level = '0;
  logic [4:0]  req_cause = '0;
  logic        nmi_n = 1'b1;
  logic        sw_ie_we = 0, sw_ie_val = 0;
  logic        irq_ack, busy, ie_out;
  logic [4:0]  irq_ack_cause;
  logic [2:0]  il_out;
  logic [31:0] sp_out, stk_addr, stk_wdata, stk_rdata, vec_addr, vec_rdata, pc_out;
  logic        stk_valid, stk_ready, stk_write, vec_valid, vec_ready, pc_load;

  int n_chk = 0, n_fail = 0;
  int ack_cnt = 0, wr_n = 0, rd_n = 0, stall_cfg = 0, stall_cnt = 0;
  logic [31:0] wr_addr [0:15];
  logic [31:0] wr_data [0:15];
  logic [31:0] rd_addr [0:15];
  logic [31:0] mem [0:63];
  logic [31:0] last_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ret_cmd(ret_cmd),
    .pc_in(pc_in), .req_valid(req_valid), .req_level(req_level),
    .req_cause(req_cause), .nmi_n(nmi_n), .sw_ie_we(sw_ie_we),
    .sw_ie_val(sw_ie_val), .irq_ack(irq_ack), .irq_ack_cause(irq_ack_cause),
    .busy(busy), .ie_out(ie_out), .il_out(il_out), .sp_out(sp_out),
    .stk_valid(stk_valid), .stk_ready(stk_ready), .stk_write(stk_write),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr),
    .vec_rdata(vec_rdata), .pc_load(pc_load), .pc_out(pc_out)
  );

  // memory and vector responders
  assign stk_ready = stk_valid && (stall_cnt >= stall_cfg);
  assign stk_rdata = mem[stk_addr[7:2]];
  assign vec_ready = vec_valid;
  assign vec_rdata = 32'h4000_0000 | vec_addr;

  always @(posedge clk) begin
    if (irq_ack) ack_cnt <= ack_cnt + 1;
    if (stk_valid && !stk_ready) stall_cnt <= stall_cnt + 1;
    else stall_cnt <= 0;
    if (stk_valid && stk_ready) begin
      if (stk_write) begin
        mem[stk_addr[7:2]] <= stk_wdata;
        wr_addr[wr_n[3:0]] <= stk_addr;
        wr_data[wr_n[3:0]] <= stk_wdata;
        wr_n <= wr_n + 1;
      end else begin
        rd_addr[rd_n[3:0]] <= stk_addr;
        rd_n <= rd_n + 1;
      end
    end
    if (vec_valid && vec_ready) last_vec <= vec_addr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_load(input string req);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pc_load) return;
    end
    chk(req, 32'hDEAD, 32'h0);
  endtask

  task automatic sw_ie(input logic v);
    @(negedge clk);
    sw_ie_we = 1; sw_ie_val = v;
    @(negedge clk);
    sw_ie_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 ie", ie_out, 0);
    chk("R1 il", il_out, 0);
    chk("R1 busy", busy, 0);
    chk("R1 sp", sp_out, 32'h100);
    chk("R1 valid", {stk_valid, vec_valid}, 0);
  endtask

  task automatic t_disabled;
    int a0 = ack_cnt;
    @(negedge clk);
    req_valid = 1; req_level = 5; req_cause = 9; instr_done = 1;
    repeat (5) @(negedge clk);
    req_valid = 0; instr_done = 0;
    chk("R2 no ack while disabled", ack_cnt - a0, 0);
    chk("R2 not busy", busy, 0);
  endtask

  task automatic t_first_entry;
    int a0;
    sw_ie(1);
    a0 = ack_cnt;
    req_valid = 1; req_level = 0; req_cause = 7; instr_done = 1;
    repeat (3) @(negedge clk);
    chk("R3 level equal to 0 rejected", ack_cnt - a0, 0);
    pc_in = 32'h0000_2468; req_level = 3;
    #1;
    chk("R12 ack", irq_ack, 1);
    chk("R12 ack cause", irq_ack_cause, 7);
    @(negedge clk);
    req_valid = 0; instr_done = 0;
    chk("R8 busy after accept", busy, 1);
    wait_load("R7 load timeout");
    chk("R5 push count", wr_n, 2);
    chk("R5 pc addr", wr_addr[0], 32'hFC);
    chk("R5 pc data", wr_data[0], 32'h2468);
    chk("R5 sr addr", wr_addr[1], 32'hF8);
    chk("R5 sr data", wr_data[1], 32'h1);
    chk("R6 ie cleared", ie_out, 0);
    chk("R6 il loaded", il_out, 3);
    chk("R7 vector addr", last_vec, 32'h101C);
    chk("R7 pc_out", pc_out, 32'h4000_101C);
    chk("R8 busy falls with load", busy, 0);
    chk("R5 sp", sp_out, 32'hF8);
  endtask

  task automatic t_nested_stall;
    int a0;
    stall_cfg = 3;
    sw_ie(1);
    a0 = ack_cnt;
    req_valid = 1; req_level = 3; req_cause = 12; instr_done = 1;
    repeat (3) @(negedge clk);
    chk("R3 equal level rejected", ack_cnt - a0, 0);
    pc_in = 32'h0000_3000; req_level = 6;
    wait_load("R11 load timeout");
    repeat (4) @(negedge clk);
    req_valid = 0; instr_done = 0;
    chk("R8 one ack while held", ack_cnt - a0, 1);
    chk("R11 il nested", il_out, 6);
    chk("R10 pc addr stalled", wr_addr[2], 32'hF4);
    chk("R10 pc data stalled", wr_data[2], 32'h3000);
    chk("R11 saved handler status", wr_data[3], 32'h7);
    chk("R7 vector addr 12", last_vec, 32'h1030);
    chk("R5 sp nested", sp_out, 32'hF0);
    stall_cfg = 0;
  endtask

  task automatic t_nmi;
    int a0;
    sw_ie(1);
    nmi_n = 0;
    @(negedge clk);
    a0 = ack_cnt;
    pc_in = 32'h0000_5554;
    req_valid = 1; req_level = 7; req_cause = 20; instr_done = 1;
    #1;
    chk("R4 nmi wins ack", irq_ack, 1);
    chk("R4 nmi cause", irq_ack_cause, 2);
    @(negedge clk);
    req_valid = 0; instr_done = 0;
    wait_load("R4 load timeout");
    chk("R4 vector addr", last_vec, 32'h1008);
    chk("R4 ie cleared", ie_out, 0);
    chk("R4 il unchanged", il_out, 6);
    chk("R4 saved status", wr_data[5], 32'hD);
    instr_done = 1;
    repeat (4) @(negedge clk);
    instr_done = 0;
    nmi_n = 1;
    chk("R4 single entry per edge", ack_cnt - a0, 1);
  endtask

  task automatic t_return(input logic [31:0] exp_pc, input logic [2:0] exp_il,
                          input logic [31:0] exp_sp);
    int r0 = rd_n;
    logic [31:0] base = sp_out;
    @(negedge clk);
    ret_cmd = 1;
    @(negedge clk);
    ret_cmd = 0;
    wait_load("R9 load timeout");
    chk("R9 pop count", rd_n - r0, 2);
    chk("R9 pc pop addr", rd_addr[r0[3:0]], base + 4);
    chk("R9 sr pop addr", rd_addr[r0[3:0] + 4'd1], base);
    chk("R9 pc restored", pc_out, exp_pc);
    chk("R9 ie restored", ie_out, 1);
    chk("R9 il restored", il_out, exp_il);
    chk("R9 sp", sp_out, exp_sp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_first_entry();
    t_nested_stall();
    t_nmi();
    t_return(32'h5554, 3'd6, 32'hF0);
    t_return(32'h3000, 3'd3, 32'hF8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule